// File: doc/BRIEF.md
# Logarithmic-Depth Prefix Binary Adder

This block adds two unsigned k-bit operands and a one-bit carry-in, and returns a k-bit sum with a carry-out. It has no clock and no state. The outputs follow the inputs within the same time step. It is meant as the adder core inside a datapath. The caller decides what the operands mean, including any two's-complement reading of the result.

The carries do not ripple from bit to bit. Each bit first produces a generate flag (both operand bits set) and a propagate flag (exactly one operand bit set). A prefix tree then merges these flags in three steps:

- Neighbouring bit pairs are combined into two-bit spans.
- A network of half the width is applied recursively to those spans. This yields every prefix that ends on an odd bit.
- One final row of merge cells forms the prefixes that end on an even bit.

The carry into bit i+1 is then the generate of span [0,i], or the propagate of that span together with the carry-in. The logic depth grows with log2(k), not with k. The operand width is a parameter and must be a power of two, at least 2.

Top module: `ppa_adder`

## Requirements
- R1: When no bit position has both operand bits set and the carry-in is 0, the sum equals the bitwise OR of the operands and the carry-out is 0. All-zero operands with the carry-in at 0 give a sum of 0 and a carry-out of 0.
- R2: For every pair of operands and either carry-in value, {carry-out, sum} equals a + b + carry-in, computed as a (k+1)-bit unsigned number.
- R3: The carry-out is bit k of the full total. An all-ones operand plus an operand of 1 gives a sum of 0 and a carry-out of 1. Two all-ones operands give a sum of all ones except bit 0, and a carry-out of 1 (with the carry-in at 0).
- R4: The carry-in adds exactly one. An all-ones operand plus zero with the carry-in at 1 gives a sum of 0 and a carry-out of 1. Zero plus zero with the carry-in at 1 gives a sum of 1.
- R5: A carry generated at any bit position j reaches the carry-out when every higher position propagates. With a = all ones from bit j upward and b = 2^j, the carry-out is 1 and the sum equals a + b mod 2^k.
- R6: The width parameter is accepted for each power of two of at least 2. The block meets R2 at widths 2, 4, 8 and 32.
- R7: The block is purely combinational. The outputs reflect new inputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | K | First operand |
| b_i | input | K | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | K | Sum bits |
| cout_o | output | 1 | Carry out of bit K-1 |

## Verification
The hardest case to reach from the ports is the longest carry path. In that case a carry created at one low bit must cross every level of the tree, including the fill-in row, to reach both the top sum bit and the carry-out. Random operands almost never produce a long propagate run at 32 bits. For that reason the bench sweeps every operand pair and both carry-in values at widths 2, 4 and 8, where every path through the tree is covered. At 32 bits it drives a generate at each bit position, with propagates on all bits above it, along with the all-ones corner cases.

// File: rtl/ppa_pkg.sv
`timescale 1ns/1ps
package ppa_pkg;
    // Smallest legal operand width for the prefix tree.
    localparam int MIN_WIDTH = 2;

    // True when w is a power of two no smaller than MIN_WIDTH.
    function automatic bit width_ok(input int w);
        return (w >= MIN_WIDTH) && ((w & (w - 1)) == 0);
    endfunction
endpackage

// File: rtl/ppa_gp_cell.sv
`timescale 1ns/1ps
// Per-bit generate / propagate flags.
module ppa_gp_cell (
    input  logic x_i,
    input  logic y_i,
    output logic g_o,
    output logic p_o
);
    assign g_o = x_i & y_i;
    assign p_o = x_i ^ y_i;

    // A single bit cannot both create and pass on a carry (R1).
    always_comb begin
        assert_bit_gp_exclusive_R1: assert (!(g_o && p_o))
            else $error("bit generate and propagate both high");
    end
endmodule

// File: rtl/ppa_merge.sv
`timescale 1ns/1ps
// Carry operator: merges a high span with the adjacent low span below it.
module ppa_merge (
    input  logic hi_g_i,
    input  logic hi_p_i,
    input  logic lo_g_i,
    input  logic lo_p_i,
    output logic g_o,
    output logic p_o
);
    assign g_o = hi_g_i | (hi_p_i & lo_g_i);
    assign p_o = hi_p_i & lo_p_i;

    // If both input spans are well formed, the merged span is too (R1).
    always_comb begin
        if (!(hi_g_i && hi_p_i) && !(lo_g_i && lo_p_i)) begin
            assert_span_gp_exclusive_R1: assert (!(g_o && p_o))
                else $error("merged span generate and propagate both high");
        end
    end
endmodule

// File: rtl/ppa_bk_tree.sv
`timescale 1ns/1ps
// Recursive prefix tree: pair row, half-width subtree, fill-in row.
// Output bit i holds generate/propagate of span [0,i].
module ppa_bk_tree #(
    parameter int N = 32
) (
    input  logic [N-1:0] g_i,
    input  logic [N-1:0] p_i,
    output logic [N-1:0] g_o,
    output logic [N-1:0] p_o
);
    if (N == 2) begin : g_leaf
        assign g_o[0] = g_i[0];
        assign p_o[0] = p_i[0];
        ppa_merge u_top (
            .hi_g_i (g_i[1]), .hi_p_i (p_i[1]),
            .lo_g_i (g_i[0]), .lo_p_i (p_i[0]),
            .g_o    (g_o[1]), .p_o    (p_o[1])
        );
    end else begin : g_rec
        localparam int H = N / 2;
        logic [H-1:0] pair_g, pair_p;
        logic [H-1:0] sub_g, sub_p;

        // Pair row: span [2j, 2j+1].
        for (genvar j = 0; j < H; j++) begin : g_pair
            ppa_merge u_pair (
                .hi_g_i (g_i[2*j+1]), .hi_p_i (p_i[2*j+1]),
                .lo_g_i (g_i[2*j]),   .lo_p_i (p_i[2*j]),
                .g_o    (pair_g[j]),  .p_o    (pair_p[j])
            );
        end

        // Half-width subtree: prefix [0, 2j+1].
        ppa_bk_tree #(.N(H)) u_sub (
            .g_i (pair_g), .p_i (pair_p),
            .g_o (sub_g),  .p_o (sub_p)
        );

        for (genvar j = 0; j < H; j++) begin : g_odd
            assign g_o[2*j+1] = sub_g[j];
            assign p_o[2*j+1] = sub_p[j];
        end

        assign g_o[0] = g_i[0];
        assign p_o[0] = p_i[0];

        // Fill-in row: prefix [0, 2j] from bit 2j and prefix [0, 2j-1].
        for (genvar j = 1; j < H; j++) begin : g_fill
            ppa_merge u_fill (
                .hi_g_i (g_i[2*j]),   .hi_p_i (p_i[2*j]),
                .lo_g_i (sub_g[j-1]), .lo_p_i (sub_p[j-1]),
                .g_o    (g_o[2*j]),   .p_o    (p_o[2*j])
            );
        end
    end

    // A prefix that propagates end to end implies every shorter prefix does (R5).
    always_comb begin
        for (int i = 1; i < N; i++) begin
            if (p_o[i]) begin
                assert_prefix_prop_chain_R5: assert (p_o[i-1])
                    else $error("prefix propagate chain broken at %0d", i);
            end
        end
    end
endmodule

// File: rtl/ppa_adder.sv
`timescale 1ns/1ps
// Top: k-bit adder with a logarithmic-depth prefix carry network.
module ppa_adder #(
    parameter int K = 32
) (
    input  logic [K-1:0] a_i,
    input  logic [K-1:0] b_i,
    input  logic         cin_i,
    output logic [K-1:0] sum_o,
    output logic         cout_o
);
    logic [K-1:0] bit_g, bit_p;
    logic [K-1:0] pre_g, pre_p;
    logic [K:0]   carry;

    initial begin
        assert_width_pow2_R6: assert (ppa_pkg::width_ok(K))
            else $error("width %0d is not a power of two >= 2", K);
    end

    for (genvar i = 0; i < K; i++) begin : g_bits
        ppa_gp_cell u_gp (
            .x_i (a_i[i]), .y_i (b_i[i]),
            .g_o (bit_g[i]), .p_o (bit_p[i])
        );
    end

    ppa_bk_tree #(.N(K)) u_tree (
        .g_i (bit_g), .p_i (bit_p),
        .g_o (pre_g), .p_o (pre_p)
    );

    assign carry[0] = cin_i;
    for (genvar i = 0; i < K; i++) begin : g_carry
        assign carry[i+1] = pre_g[i] | (pre_p[i] & cin_i);
    end

    assign sum_o  = bit_p ^ carry[K-1:0];
    assign cout_o = carry[K];

    // Result agrees with the arithmetic total (R2).
    always_comb begin
        assert_total_matches_R2: assert ({cout_o, sum_o} ==
                ({1'b0, a_i} + {1'b0, b_i} + {{K{1'b0}}, cin_i}))
            else $error("adder total mismatch");
        // When every bit propagates, the carry-in passes straight out (R4).
        if (&bit_p) begin
            assert_full_propagate_R4: assert (cout_o == cin_i && sum_o == {K{~cin_i}})
                else $error("full-propagate case wrong");
        end
    end
endmodule

// File: tb/test_ppa_adder.sv
`timescale 1ns/1ps
module test_ppa_adder;
    logic clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    logic [1:0]  a2, b2, s2;   logic c2, co2;
    logic [3:0]  a4, b4, s4;   logic c4, co4;
    logic [7:0]  a8, b8, s8;   logic c8, co8;
    logic [31:0] a32, b32, s32; logic c32, co32;

    ppa_adder #(.K(2)) i_ppa_adder_w2 (.a_i(a2), .b_i(b2), .cin_i(c2), .sum_o(s2), .cout_o(co2));
    ppa_adder #(.K(4)) i_ppa_adder_w4 (.a_i(a4), .b_i(b4), .cin_i(c4), .sum_o(s4), .cout_o(co4));
    ppa_adder #(.K(8)) i_ppa_adder_w8 (.a_i(a8), .b_i(b8), .cin_i(c8), .sum_o(s8), .cout_o(co8));
    ppa_adder i_ppa_adder (.a_i(a32), .b_i(b32), .cin_i(c32), .sum_o(s32), .cout_o(co32));

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive32(input logic [31:0] a, input logic [31:0] b, input logic c);
        a32 = a; b32 = b; c32 = c;
        #1;
    endtask

    function automatic logic [63:0] model32(input logic [31:0] a, input logic [31:0] b, input logic c);
        return {32'd0, a} + {32'd0, b} + {63'd0, c};
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R7 watchdog actual=%0d expected<=150000 cycles", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        a2 = '0; b2 = '0; c2 = 0; a4 = '0; b4 = '0; c4 = 0;
        a8 = '0; b8 = '0; c8 = 0; a32 = '0; b32 = '0; c32 = 0;
        #5;
        // R1: all-zero inputs give zero outputs.
        chk("R1 zero", {31'd0, co32, s32}, 64'd0);

        // R1: disjoint operands without carry-in give the OR.
        drive32(32'hA5A5_0F0F, 32'h5A5A_F0F0, 1'b0);
        chk("R1 disjoint", {31'd0, co32, s32}, {32'd0, 32'hFFFF_FFFF});
        drive32(32'h1248_0000, 32'h0000_8421, 1'b0);
        chk("R1 disjoint2", {31'd0, co32, s32}, {32'd0, 32'h1248_8421});

        // R3: all-ones plus one wraps to zero with carry-out.
        drive32(32'hFFFF_FFFF, 32'd1, 1'b0);
        chk("R3 ones+1", {31'd0, co32, s32}, {31'd0, 1'b1, 32'd0});
        drive32(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
        chk("R3 ones+ones", {31'd0, co32, s32}, {31'd0, 1'b1, 32'hFFFF_FFFE});

        // R4: carry-in adds exactly one.
        drive32(32'hFFFF_FFFF, 32'd0, 1'b1);
        chk("R4 ones+cin", {31'd0, co32, s32}, {31'd0, 1'b1, 32'd0});
        drive32(32'd0, 32'd0, 1'b1);
        chk("R4 zero+cin", {31'd0, co32, s32}, 64'd1);
        drive32(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);
        chk("R4 ones+ones+cin", {31'd0, co32, s32}, {31'd0, 1'b1, 32'hFFFF_FFFF});

        // R5: generate at each position with propagates above it.
        for (int j = 0; j < 32; j++) begin
            logic [31:0] a, b;
            a = 32'hFFFF_FFFF << j;
            b = 32'd1 << j;
            drive32(a, b, 1'b0);
            chk($sformatf("R5 gen at %0d", j), {31'd0, co32, s32}, model32(a, b, 1'b0));
            chk($sformatf("R5 cout at %0d", j), {63'd0, co32}, 64'd1);
        end

        // R7: new inputs appear at the outputs with no clock edge between.
        @(negedge clk);
        a32 = 32'h7FFF_FFFF; b32 = 32'd1; c32 = 1'b0;
        #2;
        chk("R7 no-clock update", {31'd0, co32, s32}, {32'd0, 32'h8000_0000});

        // R2/R6: exhaustive at widths 2, 4 and 8.
        for (int a = 0; a < 4; a++) for (int b = 0; b < 4; b++) for (int c = 0; c < 2; c++) begin
            a2 = a[1:0]; b2 = b[1:0]; c2 = c[0];
            #1;
            chk("R2 R6 w2", {61'd0, co2, s2}, 64'(a + b + c));
        end
        for (int a = 0; a < 16; a++) for (int b = 0; b < 16; b++) for (int c = 0; c < 2; c++) begin
            a4 = a[3:0]; b4 = b[3:0]; c4 = c[0];
            #1;
            chk("R2 R6 w4", {59'd0, co4, s4}, 64'(a + b + c));
        end
        for (int a = 0; a < 256; a++) for (int b = 0; b < 256; b++) for (int c = 0; c < 2; c++) begin
            a8 = a[7:0]; b8 = b[7:0]; c8 = c[0];
            #1;
            chk("R2 R6 w8", {55'd0, co8, s8}, 64'(a + b + c));
        end

        // R2: random operands at the default width.
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] a, b;
            logic c;
            a = $urandom; b = $urandom; c = $urandom_range(0, 1);
            if (n % 4 == 1) b = ~a;
            drive32(a, b, c);
            chk("R2 random w32", {31'd0, co32, s32}, model32(a, b, c));
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule